// File: doc/BRIEF.md
# Prioritized UART Interrupt Identifier

This block collects the interrupt sources of a serial port (receive line errors, received data, receive character timeout, transmit holding register empty and modem status change) and reduces them to one registered, active-high interrupt line and an 8-bit identification byte. Software reads that byte to learn which source is the most urgent. It also holds the 4-bit interrupt enable register.

The block receives level and pulse information from the rest of the port: error pulses from the receiver, the receive FIFO fill count and trigger selection, data-ready for the single-buffer mode, the transmit-empty level and the modem change request. It also receives the read strobes for the identification, line-status and receive-buffer registers. From these it applies the trigger comparison, the character-timeout timer and the rules for clearing a source when a register is read.

Top module: `uart_irq_prioritizer`

## Requirements
- R1: After reset the identification byte is 0x01 (no interrupt pending, code 000), the interrupt output is 0 and the enable register reads 0x00.
- R2: A write to the enable register stores bits 3:0 only. Bits 7:4 always read 0. Bit 0 enables received data and character timeout, bit 1 enables transmit empty, bit 2 enables line status and bit 3 enables modem status.
- R3: The identification code sits in byte bits 3:1. Line status is 011 and has the highest priority. Received data available is 010, followed by character timeout 110 at the same level. Transmit empty is 001. Modem status is 000 and has the lowest priority.
- R4: Bit 0 of the identification byte is 0 while an enabled source is pending and 1 otherwise. The registered interrupt output is its complement.
- R5: A pulse on any of the overrun, parity, framing or break error inputs latches the line-status source. A line-status register read with no new error clears it.
- R6: When FIFO mode is off, the received-data source follows the data-ready input.
- R7: When FIFO mode is on, the received-data source is active while the FIFO count is at least the trigger level. Trigger code 00 selects 1 byte, 01 selects 4, 10 selects 8 and 11 selects 14.
- R8: A read of the identification byte that returns code 001 with pending set clears the transmit-empty source. The source sets again on a new low-to-high change of the transmit-empty input, or on a write to the enable register while the transmitter is empty.
- R9: In FIFO mode with a nonzero FIFO count, the character-timeout source sets after 4*CHAR_CYCLES clocks with no receive push and no buffer read. A buffer read clears it.
- R10: Byte bits 7:6 read 11 in FIFO mode and 00 otherwise. Bits 5:4 always read 0.
- R11: A source whose enable bit is 0 does not raise the interrupt output. A latched line-status source is still reported once its enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ien_wr | input | 1 | Enable register write strobe |
| ien_wdata | input | 8 | Enable register write data |
| ien_q | output | 8 | Enable register read value |
| line_err | input | 4 | Error pulses: overrun, parity, framing, break |
| lsr_rd | input | 1 | Line-status register read strobe |
| data_ready | input | 1 | Received byte present (non-FIFO mode) |
| fifo_mode | input | 1 | FIFOs enabled |
| trig_sel | input | 2 | Receive trigger level code |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_push | input | 1 | Byte written into receive FIFO |
| rx_pop | input | 1 | Receive buffer read strobe |
| thr_empty | input | 1 | Transmit holding register empty |
| modem_req | input | 1 | Modem status change pending |
| iir_rd | input | 1 | Identification register read strobe |
| iir | output | 8 | Identification byte |
| irq | output | 1 | Registered interrupt, active high |

## Verification
The assertions check several rules on every cycle. The enable register must capture the written low nibble. The interrupt output must always complement the pending bit. A line-status source must be reported with code 011 on the next cycle and cleared by a register read. In non-FIFO mode, data-ready must produce code 010 when nothing outranks it. A buffer read must drop the timeout source. An identification read that returns the transmit-empty code must drop that source. Only the bench scenarios show the full priority ladder as sources are added and removed, the four trigger thresholds at their exact boundaries, the length of the timeout window, and the re-arming of the transmit-empty source.

// File: rtl/uart_irq_prioritizer.sv
module uart_irq_prioritizer #(
  parameter int CNT_W       = 5,
  parameter int CHAR_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ien_wr,
  input  logic [7:0]       ien_wdata,
  output logic [7:0]       ien_q,
  input  logic [3:0]       line_err,
  input  logic             lsr_rd,
  input  logic             data_ready,
  input  logic             fifo_mode,
  input  logic [1:0]       trig_sel,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             thr_empty,
  input  logic             modem_req,
  input  logic             iir_rd,
  output logic [7:0]       iir,
  output logic             irq
);
  localparam int TO_LIM = 4 * CHAR_CYCLES;
  localparam int TO_W   = $clog2(TO_LIM + 1);

  logic [3:0] en;
  logic       ls_pend, thre_pend, to_pend, thr_d;
  logic [TO_W-1:0] idle;
  logic [2:0] id_q, id_n;
  logic       pend_n_q, irq_q, any_n;
  logic [CNT_W-1:0] trig_lvl;
  logic       rda;

  assign ien_q = {4'b0000, en};
  assign iir   = {{2{fifo_mode}}, 2'b00, id_q, pend_n_q};
  assign irq   = irq_q;

  always_comb begin
    case (trig_sel)
      2'b00:   trig_lvl = CNT_W'(1);
      2'b01:   trig_lvl = CNT_W'(4);
      2'b10:   trig_lvl = CNT_W'(8);
      default: trig_lvl = CNT_W'(14);
    endcase
  end

  assign rda = fifo_mode ? (rx_count >= trig_lvl) : data_ready;

  always_comb begin
    any_n = 1'b1;
    id_n  = 3'b000;
    if (en[2] && ls_pend)          begin id_n = 3'b011; any_n = 1'b0; end
    else if (en[0] && rda)         begin id_n = 3'b010; any_n = 1'b0; end
    else if (en[0] && to_pend)     begin id_n = 3'b110; any_n = 1'b0; end
    else if (en[1] && thre_pend)   begin id_n = 3'b001; any_n = 1'b0; end
    else if (en[3] && modem_req)   begin id_n = 3'b000; any_n = 1'b0; end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en        <= '0;
      ls_pend   <= 1'b0;
      thre_pend <= 1'b0;
      thr_d     <= 1'b0;
      to_pend   <= 1'b0;
      idle      <= '0;
      id_q      <= 3'b000;
      pend_n_q  <= 1'b1;
      irq_q     <= 1'b0;
    end else begin
      if (ien_wr) en <= ien_wdata[3:0];

      if (|line_err)   ls_pend <= 1'b1;
      else if (lsr_rd) ls_pend <= 1'b0;

      thr_d <= thr_empty;
      if (!thr_empty)
        thre_pend <= 1'b0;
      else if (!thr_d || ien_wr)
        thre_pend <= 1'b1;
      else if (iir_rd && !pend_n_q && id_q == 3'b001)
        thre_pend <= 1'b0;

      if (!fifo_mode || rx_count == '0 || rx_push || rx_pop) begin
        idle <= '0;
      end else if (idle != TO_W'(TO_LIM)) begin
        idle <= idle + 1'b1;
      end
      if (!fifo_mode || rx_count == '0 || rx_pop)
        to_pend <= 1'b0;
      else if (!rx_push && idle == TO_W'(TO_LIM - 1))
        to_pend <= 1'b1;

      id_q     <= id_n;
      pend_n_q <= any_n;
      irq_q    <= !any_n;
    end
  end

  assert_ien_capture_R2: assert property (@(posedge clk) disable iff (rst)
    ien_wr |=> ien_q[3:0] == $past(ien_wdata[3:0]));

  assert_irq_vs_pending_R4: assert property (@(posedge clk) disable iff (rst)
    irq != iir[0]);

  assert_ls_top_priority_R3: assert property (@(posedge clk) disable iff (rst)
    (ls_pend && en[2] && !ien_wr) |=> (iir[3:1] == 3'b011 && !iir[0]));

  assert_ls_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd && line_err == 4'b0000) |=> !ls_pend);

  assert_rda_follows_ready_R6: assert property (@(posedge clk) disable iff (rst)
    (!fifo_mode && data_ready && en[0] && !(ls_pend && en[2]) && !ien_wr)
      |=> (iir[3:1] == 3'b010 && !iir[0]));

  assert_thre_read_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (iir_rd && !iir[0] && iir[3:1] == 3'b001 && thr_d && !ien_wr) |=> !thre_pend);

  assert_timeout_pop_clear_R9: assert property (@(posedge clk) disable iff (rst)
    rx_pop |=> !to_pend);
endmodule

// File: tb/uart_irq_prioritizer_test.sv
module uart_irq_prioritizer_test;
  localparam int CNT_W = 5;
  localparam int CHAR_CYCLES = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ien_wr = 0;
  logic [7:0] ien_wdata = 0;
  logic [7:0] ien_q;
  logic [3:0] line_err = 0;
  logic lsr_rd = 0, data_ready = 0, fifo_mode = 0;
  logic [1:0] trig_sel = 0;
  logic [CNT_W-1:0] rx_count = 0;
  logic rx_push = 0, rx_pop = 0, thr_empty = 0, modem_req = 0, iir_rd = 0;
  logic [7:0] iir;
  logic irq;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  uart_irq_prioritizer #(.CNT_W(CNT_W), .CHAR_CYCLES(CHAR_CYCLES)) uut (
    .clk(clk), .rst(rst), .ien_wr(ien_wr), .ien_wdata(ien_wdata), .ien_q(ien_q),
    .line_err(line_err), .lsr_rd(lsr_rd), .data_ready(data_ready),
    .fifo_mode(fifo_mode), .trig_sel(trig_sel), .rx_count(rx_count),
    .rx_push(rx_push), .rx_pop(rx_pop), .thr_empty(thr_empty),
    .modem_req(modem_req), .iir_rd(iir_rd), .iir(iir), .irq(irq));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_iir(input string req, input logic [7:0] exp);
    checks++;
    if (iir !== exp || irq !== !exp[0]) begin
      fails++;
      $display("FAIL %s: iir=%02h irq=%b expected iir=%02h irq=%b", req, iir, irq, exp, !exp[0]);
    end
  endtask

  task automatic wr_ien(input logic [7:0] v);
    ien_wdata = v; ien_wr = 1; tick(1); ien_wr = 0; tick(3);
  endtask

  task automatic pulse_lsr_rd();
    lsr_rd = 1; tick(1); lsr_rd = 0; tick(3);
  endtask

  task automatic pulse_iir_rd();
    iir_rd = 1; tick(1); iir_rd = 0; tick(3);
  endtask

  task automatic t_reset();
    check_iir("R1", 8'h01);
    checks++;
    if (ien_q !== 8'h00) begin fails++; $display("FAIL R1: ien_q=%02h expected 00", ien_q); end
  endtask

  task automatic t_ien();
    wr_ien(8'hFF);
    checks++;
    if (ien_q !== 8'h0F) begin fails++; $display("FAIL R2: ien_q=%02h expected 0F", ien_q); end
    wr_ien(8'h00);
  endtask

  task automatic t_priority();
    wr_ien(8'h0F);
    modem_req = 1; tick(3);  check_iir("R3 modem", 8'h00);
    thr_empty = 1; tick(3);  check_iir("R3 thre", 8'h02);
    data_ready = 1; tick(3); check_iir("R6 rda", 8'h04);
    line_err = 4'b0100; tick(1); line_err = 0; tick(3);
    check_iir("R5 ls", 8'h06);
    pulse_lsr_rd();          check_iir("R5 ls cleared", 8'h04);
    data_ready = 0; tick(3); check_iir("R6 rda off", 8'h02);
    pulse_iir_rd();          check_iir("R8 thre read", 8'h00);
    modem_req = 0; tick(3);  check_iir("R4 idle", 8'h01);
  endtask

  task automatic t_thre_rearm();
    wr_ien(8'h02);           check_iir("R8 ien rearm", 8'h02);
    pulse_iir_rd();          check_iir("R8 cleared", 8'h01);
    thr_empty = 0; tick(2); thr_empty = 1; tick(3);
    check_iir("R8 edge rearm", 8'h02);
    thr_empty = 0; tick(3);  check_iir("R8 not empty", 8'h01);
  endtask

  task automatic t_disabled();
    wr_ien(8'h00);
    line_err = 4'b0001; tick(1); line_err = 0; tick(3);
    check_iir("R11 masked", 8'h01);
    wr_ien(8'h04);           check_iir("R11 unmasked", 8'h06);
    pulse_lsr_rd();          check_iir("R5 cleared", 8'h01);
    wr_ien(8'h00);
  endtask

  task automatic t_trigger();
    wr_ien(8'h01);
    fifo_mode = 1; tick(3);  check_iir("R10 fifo bits", 8'hC1);
    trig_sel = 2'b01; rx_count = 3; tick(3); check_iir("R7 below 4", 8'hC1);
    rx_count = 4; tick(3);   check_iir("R7 at 4", 8'hC4);
    rx_count = 0; trig_sel = 2'b10; rx_count = 7; tick(3); check_iir("R7 below 8", 8'hC1);
    rx_count = 8; tick(3);   check_iir("R7 at 8", 8'hC4);
    rx_count = 0; tick(2); trig_sel = 2'b11; rx_count = 13; tick(3); check_iir("R7 below 14", 8'hC1);
    rx_count = 14; tick(3);  check_iir("R7 at 14", 8'hC4);
    rx_count = 0; tick(2); trig_sel = 2'b00; rx_count = 1; tick(3); check_iir("R7 at 1", 8'hC4);
    rx_count = 0; tick(3);   check_iir("R7 empty", 8'hC1);
  endtask

  task automatic t_timeout();
    trig_sel = 2'b11; rx_count = 2;
    rx_push = 1; tick(1); rx_push = 0;
    tick(4*CHAR_CYCLES - 4); check_iir("R9 before window", 8'hC1);
    tick(8);                 check_iir("R9 timeout", 8'hCC);
    rx_pop = 1; rx_count = 1; tick(1); rx_pop = 0; tick(3);
    check_iir("R9 pop clears", 8'hC1);
    rx_count = 0; fifo_mode = 0; tick(3);
    check_iir("R10 non-fifo", 8'h01);
  endtask

  initial begin
    tick(3); rst = 0; tick(2);
    t_reset();
    t_ien();
    t_priority();
    t_thre_rearm();
    t_disabled();
    t_trigger();
    t_timeout();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule